// File: doc/BRIEF.md
# Instruction Prefix Collector with Restart Address Tracking

This block is the byte-serial front of an 8086-style decoder. It takes one opcode-stream byte per handshake, along with the linear address that byte was fetched from. Segment-override, repeat and lock prefix bytes are folded into a pending prefix state and produce no output. The first byte that is not a prefix is treated as the opcode. The block hands it onward in a registered output slot, together with:

- the resolved segment override;
- the repeat mode;
- the lock flag;
- two restart addresses.

The fault address is where an exception handler must restart the whole instruction, so it points at the first prefix byte. The resume address is where an interrupted repeated string operation continues. In legacy mode this is the last prefix byte only, so earlier prefixes are dropped on resume. In modern mode it is the first prefix byte.

A static mode input also selects how conflicting repeat prefixes resolve. Legacy mode keeps the first repeat prefix; modern mode keeps the last one. Segment overrides always resolve to the last one received. A prefix that means nothing to the opcode after it is taken without complaint.

Top module: `pfx_front`

## Requirements
- R1: Bytes 0x26, 0x2E, 0x36 and 0x3E are segment overrides that give out_seg codes 0 (ES), 1 (CS), 2 (SS) and 3 (DS) with out_seg_en=1. An instruction with no override reports out_seg_en=0 and out_seg=0.
- R2: When several segment overrides precede one opcode, the last one received sets out_seg.
- R3: Byte 0xF3 gives out_rep=1 (REPZ), 0xF2 gives out_rep=2 (REPNZ), and no repeat prefix gives out_rep=0. Byte 0xF0 sets out_lock=1; otherwise out_lock=0.
- R4: With late_mode=0 the first repeat prefix before an opcode sets out_rep. With late_mode=1 the last one does.
- R5: Prefix bytes produce no output. Every byte that is not one of the seven prefix values is handed off as out_opcode with the collected prefixes, whatever the opcode is (for example 0xF3 0x36 before 0xF7 is handed off normally).
- R6: out_fault_addr is the address of the first prefix byte of the instruction, or the address of the opcode byte when there is no prefix.
- R7: out_resume_addr is the address of the last prefix byte when late_mode=0, or the first prefix byte when late_mode=1. With no prefix it is the opcode address.
- R8: All prefix state clears when an opcode is handed off, so the next instruction starts with no override, no repeat and no lock.
- R9: out_valid rises in the cycle after the opcode is accepted. While out_valid=1 and out_ready=0 all outputs hold steady and in_ready=0. Otherwise in_ready=1.
- R10: A synchronous active-high rst clears out_valid and discards any pending prefixes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| late_mode | input | 1 | 0: first repeat prefix wins, resume at last prefix; 1: last repeat wins, resume at first prefix |
| in_valid | input | 1 | A stream byte is offered |
| in_ready | output | 1 | The byte is accepted this cycle |
| in_byte | input | 8 | Stream byte |
| in_addr | input | AW | Linear address of the stream byte |
| out_valid | output | 1 | Decoded opcode slot is full |
| out_ready | input | 1 | Downstream takes the slot |
| out_opcode | output | 8 | Opcode byte |
| out_seg_en | output | 1 | A segment override is present |
| out_seg | output | 2 | Segment code: 0 ES, 1 CS, 2 SS, 3 DS |
| out_rep | output | 2 | 0 none, 1 REPZ, 2 REPNZ |
| out_lock | output | 1 | Lock prefix seen |
| out_fault_addr | output | AW | Restart address for faults |
| out_resume_addr | output | AW | Restart address for an interrupted repeat |

## Verification
The bench builds the block with AW=16 instead of the 20-bit default. This keeps the vector literals short, while instruction bases spaced 16 apart still keep first-prefix, last-prefix and opcode addresses distinct.

The table covers one, two and three prefix sequences under both modes. These include conflicting repeat prefixes and chained overrides, so that first-wins and last-wins resolution give visibly different codes and addresses. Directed cases hold the output under back-pressure and reset in the middle of a prefix run.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  typedef enum logic [1:0] {
    REP_NONE = 2'd0,
    REP_Z    = 2'd1,
    REP_NZ   = 2'd2
  } rep_t;

  typedef enum logic [2:0] {
    BK_OPC   = 3'd0,
    BK_SEG   = 3'd1,
    BK_REPZ  = 3'd2,
    BK_REPNZ = 3'd3,
    BK_LOCK  = 3'd4
  } kind_t;
endpackage

// File: rtl/pfx_classify.sv
module pfx_classify
  import pfx_pkg::*;
(
  input  logic [7:0] byte_i,
  output kind_t      kind_o,
  output logic [1:0] seg_o
);
  always_comb begin
    seg_o = byte_i[4:3];
    case (byte_i)
      8'h26, 8'h2E, 8'h36, 8'h3E: kind_o = BK_SEG;
      8'hF3:                      kind_o = BK_REPZ;
      8'hF2:                      kind_o = BK_REPNZ;
      8'hF0:                      kind_o = BK_LOCK;
      default:                    kind_o = BK_OPC;
    endcase
  end
endmodule

// File: rtl/pfx_accum.sv
module pfx_accum
  import pfx_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  kind_t         kind,
  input  logic [1:0]    seg_code,
  input  logic [AW-1:0] addr,
  input  logic          late_mode,
  output logic          have_pfx,
  output logic [AW-1:0] first_addr,
  output logic [AW-1:0] last_addr,
  output logic          seg_en,
  output logic [1:0]    seg,
  output rep_t          rep,
  output logic          lock
);
  rep_t rep_new;

  always_comb begin
    rep_new = (kind == BK_REPZ) ? REP_Z : REP_NZ;
  end

  always_ff @(posedge clk) begin
    if (rst || (take && kind == BK_OPC)) begin
      have_pfx   <= 1'b0;
      first_addr <= '0;
      last_addr  <= '0;
      seg_en     <= 1'b0;
      seg        <= 2'd0;
      rep        <= REP_NONE;
      lock       <= 1'b0;
    end else if (take) begin
      have_pfx  <= 1'b1;
      last_addr <= addr;
      if (!have_pfx) first_addr <= addr;
      case (kind)
        BK_SEG: begin
          seg_en <= 1'b1;
          seg    <= seg_code;
        end
        BK_REPZ, BK_REPNZ: begin
          if (late_mode || rep == REP_NONE) rep <= rep_new;
        end
        BK_LOCK: lock <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pfx_outreg.sv
module pfx_outreg
  import pfx_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          out_ready,
  input  logic [7:0]    d_opcode,
  input  logic          d_seg_en,
  input  logic [1:0]    d_seg,
  input  rep_t          d_rep,
  input  logic          d_lock,
  input  logic [AW-1:0] d_fault,
  input  logic [AW-1:0] d_resume,
  output logic          q_valid,
  output logic [7:0]    q_opcode,
  output logic          q_seg_en,
  output logic [1:0]    q_seg,
  output rep_t          q_rep,
  output logic          q_lock,
  output logic [AW-1:0] q_fault,
  output logic [AW-1:0] q_resume
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
    end else if (load) begin
      q_valid <= 1'b1;
    end else if (out_ready) begin
      q_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_opcode <= 8'd0;
      q_seg_en <= 1'b0;
      q_seg    <= 2'd0;
      q_rep    <= REP_NONE;
      q_lock   <= 1'b0;
      q_fault  <= '0;
      q_resume <= '0;
    end else if (load) begin
      q_opcode <= d_opcode;
      q_seg_en <= d_seg_en;
      q_seg    <= d_seg;
      q_rep    <= d_rep;
      q_lock   <= d_lock;
      q_fault  <= d_fault;
      q_resume <= d_resume;
    end
  end
endmodule

// File: rtl/pfx_front.sv
module pfx_front
  import pfx_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          late_mode,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_byte,
  input  logic [AW-1:0] in_addr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_opcode,
  output logic          out_seg_en,
  output logic [1:0]    out_seg,
  output logic [1:0]    out_rep,
  output logic          out_lock,
  output logic [AW-1:0] out_fault_addr,
  output logic [AW-1:0] out_resume_addr
);
  kind_t         kind;
  logic [1:0]    seg_code;
  logic          take, load;
  logic          have_pfx, seg_en, lock;
  logic [1:0]    seg;
  rep_t          rep, q_rep;
  logic [AW-1:0] first_addr, last_addr, fault_d, resume_d;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign load     = take && (kind == BK_OPC);

  pfx_classify u_cls (
    .byte_i (in_byte),
    .kind_o (kind),
    .seg_o  (seg_code)
  );

  pfx_accum #(.AW(AW)) u_acc (
    .clk        (clk),
    .rst        (rst),
    .take       (take),
    .kind       (kind),
    .seg_code   (seg_code),
    .addr       (in_addr),
    .late_mode  (late_mode),
    .have_pfx   (have_pfx),
    .first_addr (first_addr),
    .last_addr  (last_addr),
    .seg_en     (seg_en),
    .seg        (seg),
    .rep        (rep),
    .lock       (lock)
  );

  always_comb begin
    fault_d  = have_pfx ? first_addr : in_addr;
    resume_d = !have_pfx ? in_addr : (late_mode ? first_addr : last_addr);
  end

  pfx_outreg #(.AW(AW)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .out_ready (out_ready),
    .d_opcode  (in_byte),
    .d_seg_en  (seg_en),
    .d_seg     (seg),
    .d_rep     (rep),
    .d_lock    (lock),
    .d_fault   (fault_d),
    .d_resume  (resume_d),
    .q_valid   (out_valid),
    .q_opcode  (out_opcode),
    .q_seg_en  (out_seg_en),
    .q_seg     (out_seg),
    .q_rep     (q_rep),
    .q_lock    (out_lock),
    .q_fault   (out_fault_addr),
    .q_resume  (out_resume_addr)
  );

  assign out_rep = q_rep;
endmodule

// File: rtl/pfx_front_chk.sv
module pfx_front_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [7:0]    in_byte,
  input logic          out_valid,
  input logic          out_ready,
  input logic [7:0]    out_opcode,
  input logic          out_seg_en,
  input logic [1:0]    out_seg,
  input logic [1:0]    out_rep,
  input logic [AW-1:0] out_fault_addr,
  input logic [AW-1:0] out_resume_addr
);
  // R9
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_opcode) && $stable(out_fault_addr)
                                && $stable(out_resume_addr) && $stable(out_rep));
  // R9
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);
  // R1
  no_override_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_seg_en |-> out_seg == 2'd0);
  // R3
  rep_code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_rep != 2'd3);
  // R5
  prefix_silent_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_byte == 8'h36 |=> !out_valid);
  // R5
  opcode_handoff_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_byte == 8'h90 |=> out_valid && out_opcode == 8'h90);
  // R10
  reset_clears_chk: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);
endmodule

bind pfx_front pfx_front_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_pfx_front.sv
module sim_pfx_front;
  localparam int AW = 16;
  localparam time CLK_PERIOD = 10ns;
  localparam int NV = 8;

  // [40] mode [39:38] n [37:30] p0 [29:22] p1 [21:14] p2 [13:6] op [5] segen [4:3] seg [2:1] rep [0] lock
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 2'd0, 8'h00, 8'h00, 8'h00, 8'h90, 1'b0, 2'd0, 2'd0, 1'b0},
    {1'b0, 2'd2, 8'h36, 8'hF3, 8'h00, 8'hF7, 1'b1, 2'd2, 2'd1, 1'b0},
    {1'b0, 2'd3, 8'h2E, 8'h36, 8'h3E, 8'h8B, 1'b1, 2'd3, 2'd0, 1'b0},
    {1'b0, 2'd2, 8'hF3, 8'hF2, 8'h00, 8'hA4, 1'b0, 2'd0, 2'd1, 1'b0},
    {1'b1, 2'd2, 8'hF3, 8'hF2, 8'h00, 8'hA4, 1'b0, 2'd0, 2'd2, 1'b0},
    {1'b1, 2'd3, 8'hF2, 8'h26, 8'hF3, 8'hAC, 1'b1, 2'd0, 2'd1, 1'b0},
    {1'b0, 2'd3, 8'hF0, 8'hF2, 8'hF3, 8'hAB, 1'b0, 2'd0, 2'd2, 1'b1},
    {1'b1, 2'd1, 8'hF0, 8'h00, 8'h00, 8'h87, 1'b0, 2'd0, 2'd0, 1'b1}
  };

  logic clk = 0, rst = 1, late_mode = 0, in_valid = 0, out_ready = 1;
  logic [7:0] in_byte = 0;
  logic [AW-1:0] in_addr = 0;
  logic in_ready, out_valid, out_seg_en, out_lock;
  logic [7:0] out_opcode;
  logic [1:0] out_seg, out_rep;
  logic [AW-1:0] out_fault_addr, out_resume_addr;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfx_front #(.AW(AW)) u0 (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input logic [AW-1:0] a);
    @(negedge clk);
    in_valid = 1; in_byte = b; in_addr = a;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog R9 got=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R10 reset out_valid", out_valid, 0);
    chk("R9 reset in_ready", in_ready, 1);

    for (int i = 0; i < NV; i++) begin
      logic [40:0] v;
      logic [AW-1:0] base, res;
      logic [7:0] pf [3];
      int n;
      v = VEC[i];
      n = int'(v[39:38]);
      base = AW'(16'h0100 + i * 16);
      pf[0] = v[37:30]; pf[1] = v[29:22]; pf[2] = v[21:14];
      late_mode = v[40];
      for (int k = 0; k < n; k++) put(pf[k], base + AW'(k));
      put(v[13:6], base + AW'(n));
      idle();
      res = (n == 0) ? base + AW'(n) : (v[40] ? base : base + AW'(n - 1));
      chk($sformatf("R5 vec%0d valid", i), out_valid, 1);
      chk($sformatf("R5 vec%0d opcode", i), out_opcode, v[13:6]);
      chk($sformatf("R1 R2 vec%0d seg_en", i), out_seg_en, v[5]);
      chk($sformatf("R1 R2 vec%0d seg", i), out_seg, v[4:3]);
      chk($sformatf("R3 R4 vec%0d rep", i), out_rep, v[2:1]);
      chk($sformatf("R3 vec%0d lock", i), out_lock, v[0]);
      chk($sformatf("R6 vec%0d fault", i), out_fault_addr, base);
      chk($sformatf("R7 vec%0d resume", i), out_resume_addr, res);
      @(negedge clk);
      chk($sformatf("R9 vec%0d drained", i), out_valid, 0);
    end

    // R8: after a lock instruction, a bare opcode carries nothing over
    late_mode = 0;
    put(8'hF0, 16'h0400); put(8'h2E, 16'h0401); put(8'hF2, 16'h0402); put(8'h90, 16'h0403);
    put(8'h40, 16'h0404);
    idle();
    chk("R8 next opcode", out_opcode, 8'h40);
    chk("R8 no seg", out_seg_en, 0);
    chk("R8 no rep", out_rep, 0);
    chk("R8 no lock", out_lock, 0);
    chk("R8 fault at opcode", out_fault_addr, 16'h0404);

    // R9: back-pressure holds the slot
    @(negedge clk);
    out_ready = 0;
    put(8'h36, 16'h0500); put(8'hC3, 16'h0501);
    idle();
    repeat (3) @(negedge clk);
    chk("R9 held valid", out_valid, 1);
    chk("R9 held opcode", out_opcode, 8'hC3);
    chk("R9 held in_ready", in_ready, 0);
    chk("R9 held fault", out_fault_addr, 16'h0500);
    out_ready = 1;
    @(negedge clk);
    chk("R9 released", out_valid, 0);

    // R10: reset mid-prefix discards pending override
    put(8'h36, 16'h0600);
    @(negedge clk);
    in_valid = 0; rst = 1;
    @(negedge clk);
    rst = 0;
    put(8'h90, 16'h0610);
    idle();
    chk("R10 no seg after reset", out_seg_en, 0);
    chk("R10 fault after reset", out_fault_addr, 16'h0610);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule